// File: doc/BRIEF.md
# Lane-Partitioned Vector Arithmetic Unit

This block applies one arithmetic operation to every element of a 64-bit or 128-bit vector in a single issue. The element width is picked per operation from 8, 16, 32 or 64 bits. Four operations are provided: element-wise addition, a widening multiply that turns two narrow vectors into one vector of double-width products, a narrowing right shift by an immediate, and a pairwise sum of neighbouring elements. The pairwise sum is the step used to fold a vector of partial totals down to one scalar.

Operands come from a small register file of 128-bit entries. Each entry can also be addressed as two 64-bit halves, so a write through either view lands in the same storage. A host fills the register file through a load port. It then issues operations whose results are written back to the file and are also presented on a registered result bus, with a valid strobe, one clock after issue.

Top module: `lane_simd_unit`

## Requirements
- R1: Register fields are 5-bit 64-bit-view numbers. 64-bit view k is the low half (k even) or the high half (k odd) of 128-bit entry k/2. A 128-bit view uses field bits [4:1] and ignores bit 0. A write through a 64-bit view changes only that half of the entry.
- R2: Operation code 00 adds elements. Size code 00/01/10/11 selects 8/16/32/64-bit elements, and carries never cross an element boundary. With quad=1 the operation works on 128-bit views. With quad=0 it works on 64-bit views, leaves result bits [127:64] zero and writes a 64-bit view.
- R3: Operation code 01 multiplies two 64-bit views element by element. Size 00/01 gives 8/16-bit sources and size 10 or 11 gives 32-bit sources. Sources are sign-extended when signed=1 and zero-extended when signed=0. The double-width products fill a 128-bit view.
- R4: Operation code 10 reads a 128-bit view. Size 00/01 gives 8/16-bit results and size 10 or 11 gives 32-bit results, each taken from source elements twice that width. Each element is shifted right by shamt (1 up to the source width), arithmetically when signed=1 and logically when signed=0. The low half of each shifted element is kept. The 64-bit result is written to a 64-bit view and has zero in result bits [127:64]. A shift by the full source width yields all zeros, or all ones for a negative signed element.
- R5: Operation code 11 treats the source A vector as the lower half and the source B vector as the upper half of a double-length vector. Result element j is the wrapping sum of elements 2j and 2j+1 of that vector. quad and the size code have the same meaning as for addition, and with quad=0 result bits [127:64] are zero.
- R6: res_valid_o is high exactly one cycle after a cycle with issue_i high. res_data_o then carries that operation's result and holds its value otherwise. The written-back result is visible to an operation issued in the very next cycle.
- R7: When load_i and issue_i are high in the same cycle, the load is ignored and only the operation result is written.
- R8: After reset res_valid_o and res_data_o are zero and every register entry reads as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| issue_i | input | 1 | Start an operation this cycle |
| op_i | input | 2 | Operation code |
| size_i | input | 2 | Element size code |
| signed_i | input | 1 | Signed sources for multiply and shift |
| quad_i | input | 1 | 128-bit views for add and pairwise sum |
| dst_i | input | 5 | Destination register field |
| src_a_i | input | 5 | Source A register field |
| src_b_i | input | 5 | Source B register field |
| shamt_i | input | 7 | Right-shift immediate |
| load_i | input | 1 | Write load_data_i into the register file |
| load_quad_i | input | 1 | Load through a 128-bit view |
| load_idx_i | input | 5 | Load register field |
| load_data_i | input | 128 | Load data; bits [63:0] are used for a 64-bit view |
| res_valid_o | output | 1 | Result strobe |
| res_data_o | output | 128 | Registered result |

## Verification
Addition is driven with all-ones elements plus one in each byte at every size. The positions where the carry stops show whether the boundaries follow the size code. Multiply and shift are run on operands whose elements mix the most negative, maximum positive and small values, once signed and once unsigned, so the extension mode and sign handling are exposed. Shifts of 1, 5 and the full source width separate logical from arithmetic behaviour at the edges. Writes through 64-bit views into preloaded 128-bit entries, dependent back-to-back issues, and a load collided with an issue show whether storage halves, write timing and write priority are right.

// File: rtl/simd_lane_pkg.sv
package simd_lane_pkg;
  localparam int unsigned VEC_W  = 128;
  localparam int unsigned HALF_W = VEC_W / 2;
  localparam int unsigned NBYTES = VEC_W / 8;

  typedef enum logic [1:0] {
    OP_ADD  = 2'b00,
    OP_WMUL = 2'b01,
    OP_NSHR = 2'b10,
    OP_PADD = 2'b11
  } simd_op_e;

  // Marks the first byte of an element; the carry chain is cut there.
  function automatic logic f_elem_start(input logic [3:0] byte_i, input logic [1:0] size);
    case (size)
      2'd0:    return 1'b1;
      2'd1:    return ~byte_i[0];
      2'd2:    return byte_i[1:0] == 2'd0;
      default: return byte_i[2:0] == 3'd0;
    endcase
  endfunction

  function automatic logic [VEC_W-1:0] f_lane_add(input logic [VEC_W-1:0] a,
                                                  input logic [VEC_W-1:0] b,
                                                  input logic [1:0] size);
    logic [VEC_W-1:0] r;
    logic             c;
    logic [8:0]       s;
    r = '0;
    c = 1'b0;
    for (int i = 0; i < NBYTES; i++) begin
      if (f_elem_start(4'(i), size)) c = 1'b0;
      s = {1'b0, a[8*i+:8]} + {1'b0, b[8*i+:8]} + {8'd0, c};
      r[8*i+:8] = s[7:0];
      c = s[8];
    end
    return r;
  endfunction

  function automatic logic [VEC_W-1:0] f_widen_mul(input logic [HALF_W-1:0] a,
                                                   input logic [HALF_W-1:0] b,
                                                   input logic [1:0] size,
                                                   input logic sgn);
    logic [VEC_W-1:0]  r;
    logic [HALF_W-1:0] m, m2, ea, eb, p;
    int                w;
    r  = '0;
    w  = (size == 2'd0) ? 8 : (size == 2'd1) ? 16 : 32;
    m  = (64'd1 << w) - 64'd1;
    m2 = (64'd1 << (2 * w)) - 64'd1;
    for (int i = 0; i < 8; i++) begin
      if (i < HALF_W / w) begin
        ea = (a >> (i * w)) & m;
        eb = (b >> (i * w)) & m;
        if (sgn && ea[w-1]) ea = ea | ~m;
        if (sgn && eb[w-1]) eb = eb | ~m;
        p = ea * eb;
        r = r | ({64'd0, p & m2} << (i * 2 * w));
      end
    end
    return r;
  endfunction

  function automatic logic [HALF_W-1:0] f_narrow_shr(input logic [VEC_W-1:0] src,
                                                     input logic [1:0] size,
                                                     input logic sgn,
                                                     input logic [6:0] shamt);
    logic [HALF_W-1:0] r, m, dm, e;
    logic [VEC_W-1:0]  ext, sh;
    int                sw, dw;
    r  = '0;
    dw = (size == 2'd0) ? 8 : (size == 2'd1) ? 16 : 32;
    sw = 2 * dw;
    m  = (64'd1 << sw) - 64'd1;
    dm = (64'd1 << dw) - 64'd1;
    for (int i = 0; i < 8; i++) begin
      if (i < VEC_W / sw) begin
        e   = 64'(src >> (i * sw)) & m;
        ext = {64'd0, e};
        if (sgn && e[sw-1]) ext = ext | ~{64'd0, m};
        sh  = ext >> shamt;
        r   = r | ((sh[HALF_W-1:0] & dm) << (i * dw));
      end
    end
    return r;
  endfunction

  function automatic logic [VEC_W-1:0] f_pair_add(input logic [VEC_W-1:0] a,
                                                  input logic [VEC_W-1:0] b,
                                                  input logic [1:0] size,
                                                  input logic quad);
    logic [2*VEC_W-1:0] v;
    logic [VEC_W-1:0]   r;
    logic [HALF_W-1:0]  m, x, y;
    int                 w, vbits;
    r     = '0;
    w     = 8 << size;
    vbits = quad ? VEC_W : HALF_W;
    v     = quad ? {b, a} : {128'd0, b[HALF_W-1:0], a[HALF_W-1:0]};
    m     = (64'd1 << w) - 64'd1;
    for (int j = 0; j < NBYTES; j++) begin
      if (j < vbits / w) begin
        x = 64'(v >> (2 * j * w)) & m;
        y = 64'(v >> ((2 * j + 1) * w)) & m;
        r = r | ({64'd0, (x + y) & m} << (j * w));
      end
    end
    return r;
  endfunction
endpackage

// File: rtl/simd_regfile.sv
module simd_regfile import simd_lane_pkg::*; #(
  parameter int unsigned NUM_Q = 16,
  localparam int unsigned IDX_W = $clog2(NUM_Q) + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rd_a_idx,
  input  logic             rd_a_quad,
  output logic [VEC_W-1:0] rd_a_data,
  input  logic [IDX_W-1:0] rd_b_idx,
  input  logic             rd_b_quad,
  output logic [VEC_W-1:0] rd_b_data,
  input  logic             wr_en,
  input  logic             wr_quad,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [VEC_W-1:0] wr_data
);
  logic [VEC_W-1:0] mem [NUM_Q];

  function automatic logic [VEC_W-1:0] view(input logic [VEC_W-1:0] entry,
                                            input logic quad, input logic hi);
    if (quad) return entry;
    return {64'd0, hi ? entry[VEC_W-1:HALF_W] : entry[HALF_W-1:0]};
  endfunction

  assign rd_a_data = view(mem[rd_a_idx[IDX_W-1:1]], rd_a_quad, rd_a_idx[0]);
  assign rd_b_data = view(mem[rd_b_idx[IDX_W-1:1]], rd_b_quad, rd_b_idx[0]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_Q; i++) mem[i] <= '0;
    end else if (wr_en) begin
      if (wr_quad)        mem[wr_idx[IDX_W-1:1]] <= wr_data;
      else if (wr_idx[0]) mem[wr_idx[IDX_W-1:1]][VEC_W-1:HALF_W] <= wr_data[HALF_W-1:0];
      else                mem[wr_idx[IDX_W-1:1]][HALF_W-1:0] <= wr_data[HALF_W-1:0];
    end
  end
endmodule

// File: rtl/simd_lane_alu.sv
module simd_lane_alu import simd_lane_pkg::*; (
  input  logic [1:0]       op,
  input  logic [1:0]       size,
  input  logic             sgn,
  input  logic             quad,
  input  logic [6:0]       shamt,
  input  logic [VEC_W-1:0] a,
  input  logic [VEC_W-1:0] b,
  output logic             src_quad,
  output logic             dst_quad,
  output logic [VEC_W-1:0] result
);
  always_comb begin
    src_quad = quad;
    dst_quad = quad;
    result   = '0;
    case (op)
      OP_ADD: begin
        result = f_lane_add(a, b, size);
        if (!quad) result[VEC_W-1:HALF_W] = '0;
      end
      OP_WMUL: begin
        src_quad = 1'b0;
        dst_quad = 1'b1;
        result   = f_widen_mul(a[HALF_W-1:0], b[HALF_W-1:0], size, sgn);
      end
      OP_NSHR: begin
        src_quad = 1'b1;
        dst_quad = 1'b0;
        result   = {64'd0, f_narrow_shr(a, size, sgn, shamt)};
      end
      default: begin
        result = f_pair_add(a, b, size, quad);
        if (!quad) result[VEC_W-1:HALF_W] = '0;
      end
    endcase
  end
endmodule

// File: rtl/lane_simd_unit.sv
module lane_simd_unit import simd_lane_pkg::*; #(
  parameter int unsigned NUM_Q = 16,
  localparam int unsigned IDX_W = $clog2(NUM_Q) + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             issue_i,
  input  logic [1:0]       op_i,
  input  logic [1:0]       size_i,
  input  logic             signed_i,
  input  logic             quad_i,
  input  logic [IDX_W-1:0] dst_i,
  input  logic [IDX_W-1:0] src_a_i,
  input  logic [IDX_W-1:0] src_b_i,
  input  logic [6:0]       shamt_i,
  input  logic             load_i,
  input  logic             load_quad_i,
  input  logic [IDX_W-1:0] load_idx_i,
  input  logic [VEC_W-1:0] load_data_i,
  output logic             res_valid_o,
  output logic [VEC_W-1:0] res_data_o
);
  logic             src_quad, dst_quad;
  logic [VEC_W-1:0] opnd_a, opnd_b, alu_res;
  logic             wb_en, wb_quad;
  logic [IDX_W-1:0] wb_idx;
  logic [VEC_W-1:0] wb_data;

  simd_lane_alu u_alu (
    .op(op_i), .size(size_i), .sgn(signed_i), .quad(quad_i), .shamt(shamt_i),
    .a(opnd_a), .b(opnd_b), .src_quad(src_quad), .dst_quad(dst_quad), .result(alu_res)
  );

  // An issued result takes the single write port ahead of a load.
  assign wb_en   = issue_i | load_i;
  assign wb_quad = issue_i ? dst_quad : load_quad_i;
  assign wb_idx  = issue_i ? dst_i : load_idx_i;
  assign wb_data = issue_i ? alu_res : load_data_i;

  simd_regfile #(.NUM_Q(NUM_Q)) u_rf (
    .clk(clk), .rst_n(rst_n),
    .rd_a_idx(src_a_i), .rd_a_quad(src_quad), .rd_a_data(opnd_a),
    .rd_b_idx(src_b_i), .rd_b_quad(src_quad), .rd_b_data(opnd_b),
    .wr_en(wb_en), .wr_quad(wb_quad), .wr_idx(wb_idx), .wr_data(wb_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid_o <= 1'b0;
      res_data_o  <= '0;
    end else begin
      res_valid_o <= issue_i;
      if (issue_i) res_data_o <= alu_res;
    end
  end
endmodule

// File: rtl/lane_simd_unit_chk.sv
module lane_simd_unit_chk (
  input logic         clk,
  input logic         rst_n,
  input logic         issue_i,
  input logic [1:0]   op_i,
  input logic         quad_i,
  input logic         res_valid_o,
  input logic [127:0] res_data_o
);
  p_valid_latency_r6: assert property (@(posedge clk) disable iff (!rst_n)
    issue_i |=> res_valid_o);

  p_idle_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !issue_i |=> (!res_valid_o && $stable(res_data_o)));

  p_narrow_upper_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_i && op_i == 2'b10) |=> res_data_o[127:64] == 64'd0);

  p_half_add_upper_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_i && op_i == 2'b00 && !quad_i) |=> res_data_o[127:64] == 64'd0);

  p_half_pair_upper_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_i && op_i == 2'b11 && !quad_i) |=> res_data_o[127:64] == 64'd0);

  p_known_result_r8: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid_o |-> !$isunknown(res_data_o));
endmodule

bind lane_simd_unit lane_simd_unit_chk u_chk (.*);

// File: tb/lane_simd_unit_tb.sv
module lane_simd_unit_tb;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         issue_i = 1'b0;
  logic [1:0]   op_i = '0, size_i = '0;
  logic         signed_i = 1'b0, quad_i = 1'b0;
  logic [4:0]   dst_i = '0, src_a_i = '0, src_b_i = '0;
  logic [6:0]   shamt_i = '0;
  logic         load_i = 1'b0, load_quad_i = 1'b0;
  logic [4:0]   load_idx_i = '0;
  logic [127:0] load_data_i = '0;
  logic         res_valid_o;
  logic [127:0] res_data_o;

  int checks = 0, failures = 0;
  bit done = 1'b0;
  logic [127:0] mq [16];
  logic [127:0] last_res = '0;

  always #2 clk = ~clk;

  lane_simd_unit u_dut (.*);

  function automatic logic [63:0] getf(input logic [255:0] v, input int pos, input int w);
    logic [63:0] r = '0;
    for (int k = 0; k < w; k++) r[k] = v[pos+k];
    return r;
  endfunction

  function automatic logic [255:0] putf(input logic [255:0] v, input int pos, input int w,
                                        input logic [127:0] x);
    for (int k = 0; k < w; k++) v[pos+k] = x[k];
    return v;
  endfunction

  function automatic logic [127:0] sext(input logic [63:0] x, input int w, input bit sg);
    logic [127:0] r;
    for (int k = 0; k < 128; k++) r[k] = (k < w) ? x[k] : (sg & x[w-1]);
    return r;
  endfunction

  function automatic logic [127:0] mread(input logic [4:0] idx, input bit qd);
    logic [127:0] e = mq[idx[4:1]];
    if (qd) return e;
    return idx[0] ? {64'd0, e[127:64]} : {64'd0, e[63:0]};
  endfunction

  task automatic mwrite(input logic [4:0] idx, input bit qd, input logic [127:0] d);
    if (qd) mq[idx[4:1]] = d;
    else if (idx[0]) mq[idx[4:1]][127:64] = d[63:0];
    else mq[idx[4:1]][63:0] = d[63:0];
  endtask

  task automatic check(input string tag, input bit ok, input logic [127:0] act,
                       input logic [127:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // One clock: drive at the falling edge, compare at the next falling edge.
  task automatic cyc(input bit iss, input logic [1:0] op, input logic [1:0] sz, input bit sg,
                     input bit qd, input logic [4:0] d, input logic [4:0] a, input logic [4:0] b,
                     input logic [6:0] sh, input bit ld, input bit ldq, input logic [4:0] li,
                     input logic [127:0] ldat, input string tag);
    logic [255:0] r = '0, cat;
    logic [127:0] va, vb, exp;
    int w, vbits, sw, dw;
    bit wq = qd;
    issue_i = iss; op_i = op; size_i = sz; signed_i = sg; quad_i = qd;
    dst_i = d; src_a_i = a; src_b_i = b; shamt_i = sh;
    load_i = ld; load_quad_i = ldq; load_idx_i = li; load_data_i = ldat;
    exp = last_res;
    if (iss) begin
      w = 8 << sz;
      vbits = qd ? 128 : 64;
      case (op)
        2'b00: begin
          va = mread(a, qd); vb = mread(b, qd);
          for (int n = 0; n < vbits / w; n++)
            r = putf(r, n*w, w, {64'd0, getf({128'd0, va}, n*w, w) + getf({128'd0, vb}, n*w, w)});
        end
        2'b01: begin
          va = mread(a, 0); vb = mread(b, 0); wq = 1;
          w = (sz == 0) ? 8 : (sz == 1) ? 16 : 32;
          for (int n = 0; n < 64 / w; n++)
            r = putf(r, n*2*w, 2*w, sext(getf({128'd0, va}, n*w, w), w, sg) *
                                    sext(getf({128'd0, vb}, n*w, w), w, sg));
        end
        2'b10: begin
          va = mread(a, 1); wq = 0;
          dw = (sz == 0) ? 8 : (sz == 1) ? 16 : 32;
          sw = 2 * dw;
          for (int n = 0; n < 128 / sw; n++)
            r = putf(r, n*dw, dw, sext(getf({128'd0, va}, n*sw, sw), sw, sg) >> sh);
        end
        default: begin
          va = mread(a, qd); vb = mread(b, qd);
          cat = '0;
          for (int k = 0; k < vbits; k++) begin
            cat[k] = va[k];
            cat[vbits+k] = vb[k];
          end
          for (int n = 0; n < vbits / w; n++)
            r = putf(r, n*w, w, {64'd0, getf(cat, 2*n*w, w) + getf(cat, (2*n+1)*w, w)});
        end
      endcase
      exp = r[127:0];
      mwrite(d, wq, exp);
    end else if (ld) begin
      mwrite(li, ldq, ldat);
    end
    last_res = exp;
    @(negedge clk);
    check({tag, " valid"}, res_valid_o == iss, {127'd0, res_valid_o}, {127'd0, iss});
    check(tag, res_data_o == exp, res_data_o, exp);
  endtask

  task automatic op(input logic [1:0] o, input logic [1:0] sz, input bit sg, input bit qd,
                    input logic [4:0] d, input logic [4:0] a, input logic [4:0] b,
                    input logic [6:0] sh, input string tag);
    cyc(1, o, sz, sg, qd, d, a, b, sh, 0, 0, 0, '0, tag);
  endtask

  task automatic load(input bit qd, input logic [4:0] li, input logic [127:0] dat);
    cyc(0, 0, 0, 0, 0, 0, 0, 0, 0, 1, qd, li, dat, "R6 load idle");
  endtask

  initial begin
    for (int i = 0; i < 16; i++) mq[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check("R8 reset valid", res_valid_o == 1'b0, {127'd0, res_valid_o}, 128'd0);
    check("R8 reset data", res_data_o == '0, res_data_o, 128'd0);
    op(2'b00, 2'd0, 0, 1, 5'd2, 5'd0, 5'd4, 0, "R8 regs zero");

    // R1 aliasing: 128-bit load read through its halves, half writes keep the other half
    load(1, 5'd2, 128'h0001_FFFF_8000_7FFF_FFFF_0001_1234_FFFF);
    op(2'b00, 2'd1, 0, 0, 5'd8, 5'd2, 5'd3, 0, "R1 R2 halves of Q1 add16");
    load(1, 5'd4, 128'hAAAA_BBBB_CCCC_DDDD_1111_2222_3333_4444);
    load(0, 5'd5, 128'h0123_4567_89AB_CDEF);
    op(2'b00, 2'd0, 0, 1, 5'd6, 5'd4, 5'd30, 0, "R1 high-half load keeps low");
    load(0, 5'd4, 128'h0F0F_0F0F_0F0F_0F0F);
    op(2'b00, 2'd0, 0, 1, 5'd6, 5'd4, 5'd30, 0, "R1 low-half load keeps high");

    // R2 carry cut at each size
    load(1, 5'd12, {128{1'b1}});
    load(1, 5'd14, {16{8'h01}});
    for (int s = 0; s < 4; s++) begin
      op(2'b00, 2'(s), 0, 1, 5'd20, 5'd12, 5'd14, 0, "R2 add quad");
      op(2'b00, 2'(s), 0, 0, 5'd21, 5'd12, 5'd14, 0, "R2 add half");
    end
    op(2'b00, 2'd3, 0, 1, 5'd20, 5'd12, 5'd12, 0, "R2 add 64 wrap");

    // R3 widening multiply
    load(1, 5'd16, 128'hFF80_0102_C000_0005_8000_FFFF_7FFF_0003);
    for (int s = 0; s < 4; s++) begin
      op(2'b01, 2'(s), 1, 0, 5'd18, 5'd16, 5'd17, 0, "R3 mul signed");
      op(2'b01, 2'(s), 0, 0, 5'd18, 5'd16, 5'd17, 0, "R3 mul unsigned");
    end
    op(2'b01, 2'd1, 1, 0, 5'd18, 5'd16, 5'd16, 0, "R3 mul square");

    // R4 narrowing shift, edges 1 and full width
    for (int s = 0; s < 3; s++) begin
      op(2'b10, 2'(s), 1, 0, 5'd22, 5'd16, 5'd0, 7'd1, "R4 shr signed 1");
      op(2'b10, 2'(s), 0, 0, 5'd22, 5'd16, 5'd0, 7'd1, "R4 shr unsigned 1");
      op(2'b10, 2'(s), 1, 0, 5'd23, 5'd16, 5'd0, 7'd5, "R4 shr signed 5");
      op(2'b10, 2'(s), 0, 0, 5'd23, 5'd16, 5'd0, 7'd5, "R4 shr unsigned 5");
      op(2'b10, 2'(s), 1, 0, 5'd22, 5'd16, 5'd0, 7'(16 << s), "R4 shr signed full");
      op(2'b10, 2'(s), 0, 0, 5'd22, 5'd16, 5'd0, 7'(16 << s), "R4 shr unsigned full");
    end
    op(2'b00, 2'd0, 0, 1, 5'd24, 5'd22, 5'd30, 0, "R4 R1 D-view dest only");

    // R5 pairwise sum
    for (int s = 0; s < 4; s++) begin
      op(2'b11, 2'(s), 0, 1, 5'd24, 5'd16, 5'd4, 0, "R5 pair quad");
      op(2'b11, 2'(s), 0, 0, 5'd25, 5'd16, 5'd17, 0, "R5 pair half");
    end

    // R6 back-to-back dependency and hold while idle
    op(2'b00, 2'd2, 0, 1, 5'd26, 5'd16, 5'd4, 0, "R6 produce");
    op(2'b00, 2'd2, 0, 1, 5'd26, 5'd26, 5'd26, 0, "R6 consume next cycle");
    cyc(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, '0, "R6 idle hold");
    cyc(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, '0, "R6 idle hold 2");

    // R7 load collided with an issue is dropped
    cyc(1, 2'b00, 2'd0, 0, 1, 5'd10, 5'd16, 5'd16, 0, 1, 1, 5'd28, {4{32'hDEAD_BEEF}},
        "R7 collide issue");
    op(2'b00, 2'd0, 0, 1, 5'd24, 5'd28, 5'd30, 0, "R7 load dropped");
    op(2'b00, 2'd0, 0, 1, 5'd24, 5'd10, 5'd30, 0, "R7 issue written");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: run did not finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule